// File: doc/BRIEF.md
# Dual-Range Serial Clock Divider

This block derives a serial clock for a shift engine from a faster source clock. One select bit chooses the divider. The fine range is a linear divider driven by an 8-bit ratio field. The coarse range is a power-of-two divider driven by a 4-bit exponent field, and it reaches the slow clocks that the linear range cannot. The block outputs the serial clock level with a 50% duty cycle. It also outputs three single-cycle strobes: one on every serial clock edge, one on the rising edge only and one on the falling edge only. A shift engine uses these strobes to launch and capture data without a second clock domain.

The divider fields can be rewritten at any time. The block takes a new setting into use only when a full serial clock period has ended, so a rewrite never produces a shortened pulse. When the enable input is low, the block sits in a quiet state. When enable goes high, counting restarts from zero, and the first edge is a rising edge.

Top module: `sclk_dual_div`

## Requirements
- R1: `rangeSel` = 1 selects the linear divider, which uses `linRatio`. `rangeSel` = 0 selects the power-of-two divider, which uses `expVal`.
- R2: In the linear range with `linRatio` = N, each serial clock half-period lasts N+1 source cycles. The full period is 2*(N+1) source cycles, so ratios run from 2 (N = 0) to 512 (N = 255).
- R3: In the power-of-two range with `expVal` = M and M >= 1, the full serial clock period is 2^M source cycles, so each half-period lasts 2^(M-1) cycles.
- R4: In the power-of-two range, `expVal` = 0 is treated as divide-by-1. An edge strobe appears on every source cycle, which is the same behaviour as M = 1.
- R5: `sclk` has a 50% duty cycle. `sclkRise` is high for exactly the one cycle in which `sclk` first reads 1. `sclkFall` is high for exactly the one cycle in which `sclk` first reads 0. `sclkToggle` is high in both of those cycles and in no other cycle.
- R6: While `enable` is low, `sclk` is 0 and no strobe is issued. Counting restarts from zero, so the first edge after enable rises is a rising edge. That edge appears one half-period (in source cycles) after enable is first sampled high.
- R7: A change to `rangeSel`, `linRatio` or `expVal` made while enabled affects only the periods that begin after the next falling edge. The period in progress completes with the old setting.
- R8: After reset, `sclk` and all three strobes are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Run the divider; low holds it idle |
| rangeSel | input | 1 | 1 = linear range, 0 = power-of-two range |
| linRatio | input | 8 | Linear ratio N, half-period N+1 cycles |
| expVal | input | 4 | Exponent M, period 2^M cycles |
| sclk | output | 1 | Serial clock level |
| sclkToggle | output | 1 | Strobe on every serial clock edge |
| sclkRise | output | 1 | Strobe on the rising edge |
| sclkFall | output | 1 | Strobe on the falling edge |

## Verification
The bench builds the block with its default field widths: an 8-bit ratio and a 4-bit exponent, which gives a 14-bit internal counter. With these widths the bench reaches both ends of the linear range: N = 0, which gives a 1-cycle half-period, and N = 255, which gives a 256-cycle half-period. It also runs exponents 0, 1, 3, 10 and 12, so the bench covers the divide-by-1 special case and periods beyond 512 that only the power-of-two range can produce. Mid-run rewrites of the fields are made just after a rising edge and just after a falling edge. These show that the boundary rule holds, including when the range select itself changes.

// File: rtl/sclk_div_pkg.sv
package sclk_div_pkg;

  // Command strobes issued by the control to the counting datapath
  typedef struct packed {
    logic hold;   // force counter to zero, clock low, strobes quiet
    logic wrap;   // half-period done: restart count and flip the clock
  } divCmd_t;

  function automatic int maxOf(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sclk_div_limit.sv
// Turns the active divider setting into the terminal count of one half-period.
module sclk_div_limit #(
  parameter int RATIO_W = 8,
  parameter int EXP_W   = 4,
  parameter int CNT_W   = 14
) (
  input  logic               useLin,
  input  logic [RATIO_W-1:0] ratio,
  input  logic [EXP_W-1:0]   expo,
  output logic [CNT_W-1:0]   halfLimit
);
  localparam int EXP_N = 1 << EXP_W;

  logic [CNT_W-1:0] expLut [EXP_N];

  // Terminal count for each exponent. Exponents 0 and 1 both give a
  // one-cycle half-period, so exponent 0 acts as divide-by-1.
  for (genvar k = 0; k < EXP_N; k++) begin : g_exp
    if (k <= 1) begin : g_fast
      assign expLut[k] = '0;
    end else begin : g_pow
      assign expLut[k] = (CNT_W'(1) << (k - 1)) - CNT_W'(1);
    end
  end

  always_comb begin
    if (useLin) begin
      halfLimit = CNT_W'(ratio);
    end else begin
      halfLimit = expLut[expo];
    end
  end
endmodule

// File: rtl/sclk_div_ctrl.sv
// Holds the setting in use and decides when the datapath wraps or idles.
module sclk_div_ctrl
  import sclk_div_pkg::*;
#(
  parameter int RATIO_W = 8,
  parameter int EXP_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               rangeSel,
  input  logic [RATIO_W-1:0] linRatio,
  input  logic [EXP_W-1:0]   expVal,
  input  logic               atTerm,
  input  logic               sclkNow,
  output divCmd_t            cmd,
  output logic               useLin,
  output logic [RATIO_W-1:0] ratio,
  output logic [EXP_W-1:0]   expo
);
  logic periodEnd;
  logic takeNew;

  // A full period ends when the high half wraps and the clock falls
  assign periodEnd = enable && atTerm && sclkNow;
  assign takeNew   = !enable || periodEnd;

  always_comb begin
    cmd.hold = !enable;
    cmd.wrap = enable && atTerm;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      useLin <= 1'b1;
      ratio  <= '0;
      expo   <= '0;
    end else if (takeNew) begin
      useLin <= rangeSel;
      ratio  <= linRatio;
      expo   <= expVal;
    end
  end
endmodule

// File: rtl/sclk_div_path.sv
// Half-period counter, clock level register and edge strobes.
module sclk_div_path
  import sclk_div_pkg::*;
#(
  parameter int CNT_W = 14
) (
  input  logic             clk,
  input  logic             rstN,
  input  divCmd_t          cmd,
  input  logic [CNT_W-1:0] halfLimit,
  output logic             atTerm,
  output logic             sclk,
  output logic             sclkToggle,
  output logic             sclkRise,
  output logic             sclkFall
);
  logic [CNT_W-1:0] count;

  assign atTerm = (count == halfLimit);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count      <= '0;
      sclk       <= 1'b0;
      sclkToggle <= 1'b0;
      sclkRise   <= 1'b0;
      sclkFall   <= 1'b0;
    end else if (cmd.hold) begin
      count      <= '0;
      sclk       <= 1'b0;
      sclkToggle <= 1'b0;
      sclkRise   <= 1'b0;
      sclkFall   <= 1'b0;
    end else if (cmd.wrap) begin
      count      <= '0;
      sclk       <= !sclk;
      sclkToggle <= 1'b1;
      sclkRise   <= !sclk;
      sclkFall   <= sclk;
    end else begin
      count      <= count + CNT_W'(1);
      sclkToggle <= 1'b0;
      sclkRise   <= 1'b0;
      sclkFall   <= 1'b0;
    end
  end
endmodule

// File: rtl/sclk_dual_div.sv
module sclk_dual_div
  import sclk_div_pkg::*;
#(
  parameter int RATIO_W = 8,
  parameter int EXP_W   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               enable,
  input  logic               rangeSel,
  input  logic [RATIO_W-1:0] linRatio,
  input  logic [EXP_W-1:0]   expVal,
  output logic               sclk,
  output logic               sclkToggle,
  output logic               sclkRise,
  output logic               sclkFall
);
  // Counter must hold the largest linear count and the largest power-of-two half-period
  localparam int CNT_W = maxOf(maxOf(RATIO_W, (1 << EXP_W) - 2), 1);

  divCmd_t            cmd;
  logic               atTerm;
  logic               useLin;
  logic [RATIO_W-1:0] ratio;
  logic [EXP_W-1:0]   expo;
  logic [CNT_W-1:0]   halfLimit;

  sclk_div_ctrl #(.RATIO_W(RATIO_W), .EXP_W(EXP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .enable(enable), .rangeSel(rangeSel),
    .linRatio(linRatio), .expVal(expVal), .atTerm(atTerm), .sclkNow(sclk),
    .cmd(cmd), .useLin(useLin), .ratio(ratio), .expo(expo)
  );

  sclk_div_limit #(.RATIO_W(RATIO_W), .EXP_W(EXP_W), .CNT_W(CNT_W)) u_limit (
    .useLin(useLin), .ratio(ratio), .expo(expo), .halfLimit(halfLimit)
  );

  sclk_div_path #(.CNT_W(CNT_W)) u_path (
    .clk(clk), .rstN(rstN), .cmd(cmd), .halfLimit(halfLimit), .atTerm(atTerm),
    .sclk(sclk), .sclkToggle(sclkToggle), .sclkRise(sclkRise), .sclkFall(sclkFall)
  );
endmodule

// File: rtl/sclk_dual_div_chk.sv
module sclk_dual_div_chk (
  input logic clk,
  input logic rstN,
  input logic enable,
  input logic sclk,
  input logic sclkToggle,
  input logic sclkRise,
  input logic sclkFall
);
  // R5: a rising strobe and a falling strobe never occur together
  a_r5_edges_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(sclkRise && sclkFall));

  // R5: the rising strobe coincides with a high clock
  a_r5_rise_level: assert property (@(posedge clk) disable iff (!rstN)
    sclkRise |-> sclk);

  // R5: the falling strobe coincides with a low clock
  a_r5_fall_level: assert property (@(posedge clk) disable iff (!rstN)
    sclkFall |-> !sclk);

  // R5: every clock change while running is marked by the edge strobe
  a_r5_change_marked: assert property (@(posedge clk) disable iff (!rstN)
    ($past(enable) && (sclk != $past(sclk))) |-> sclkToggle);

  // R6: a low enable leaves the clock low and the strobes quiet
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> (!sclk && !sclkToggle && !sclkRise && !sclkFall));
endmodule

bind sclk_dual_div sclk_dual_div_chk u_chk (
  .clk(clk), .rstN(rstN), .enable(enable), .sclk(sclk),
  .sclkToggle(sclkToggle), .sclkRise(sclkRise), .sclkFall(sclkFall)
);

// File: tb/sclk_dual_div_tb.sv
`timescale 1ns/1ps
module sclk_dual_div_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       enable = 1'b0;
  logic       rangeSel = 1'b1;
  logic [7:0] linRatio = '0;
  logic [3:0] expVal = '0;
  logic       sclk, sclkToggle, sclkRise, sclkFall;

  int nChecks = 0;
  int nFail   = 0;
  bit done    = 1'b0;

  always #5 clk = ~clk;

  sclk_dual_div u_dut (
    .clk(clk), .rstN(rstN), .enable(enable), .rangeSel(rangeSel),
    .linRatio(linRatio), .expVal(expVal), .sclk(sclk),
    .sclkToggle(sclkToggle), .sclkRise(sclkRise), .sclkFall(sclkFall)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    nChecks++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // Count source cycles until the next edge strobe is seen
  task automatic waitToggle(output int n);
    n = 0;
    do begin
      @(negedge clk);
      n++;
    end while (!sclkToggle && n < 70000);
  endtask

  task automatic configure(input bit lin, input int ratio, input int expo);
    @(negedge clk);
    enable   = 1'b0;
    rangeSel = lin;
    linRatio = 8'(ratio);
    expVal   = 4'(expo);
    @(negedge clk);
    @(negedge clk);
  endtask

  // Start, then measure first high half, low half and next high half
  task automatic runMode(input bit lin, input int ratio, input int expo,
                         input int half, input string tag);
    int n;
    configure(lin, ratio, expo);
    enable = 1'b1;
    waitToggle(n);
    check(n == half, {tag, " first half (R6)"}, n, half);
    check(sclk && sclkRise && !sclkFall, {tag, " first edge rises (R5)"}, sclk, 1);
    waitToggle(n);
    check(n == half, {tag, " low half"}, n, half);
    check(!sclk && sclkFall && !sclkRise, {tag, " falling strobe (R5)"}, sclk, 0);
    waitToggle(n);
    check(n == half, {tag, " duty (R5)"}, n, half);
    enable = 1'b0;
  endtask

  task automatic testReset();
    check(!sclk && !sclkToggle && !sclkRise && !sclkFall,
          "R8 reset quiet", {sclk, sclkToggle, sclkRise, sclkFall}, 0);
  endtask

  task automatic testLinear();
    runMode(1'b1, 0,   0, 1,   "R2 N=0");
    runMode(1'b1, 3,   0, 4,   "R2 N=3");
    runMode(1'b1, 255, 9, 256, "R2 N=255 (R1 exp ignored)");
  endtask

  task automatic testPower();
    runMode(1'b0, 200, 0,  1,    "R4 M=0");
    runMode(1'b0, 0,   1,  1,    "R3 M=1");
    runMode(1'b0, 7,   3,  4,    "R3 M=3 (R1 ratio ignored)");
    runMode(1'b0, 0,   10, 512,  "R3 M=10");
    runMode(1'b0, 0,   12, 2048, "R3 M=12");
  endtask

  task automatic testIdle();
    int seen;
    configure(1'b1, 0, 0);
    enable = 1'b1;
    repeat (6) @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    seen = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (sclk || sclkToggle || sclkRise || sclkFall) seen++;
    end
    check(seen == 0, "R6 idle quiet samples", seen, 0);
  endtask

  task automatic testChange();
    int n;
    configure(1'b1, 7, 0);
    enable = 1'b1;
    waitToggle(n);
    check(n == 8 && sclkRise, "R7 start half 8", n, 8);
    linRatio = 8'd1;                      // rewrite during the high half
    waitToggle(n);
    check(n == 8, "R7 high half keeps old ratio", n, 8);
    waitToggle(n);
    check(n == 2, "R7 new ratio after fall (rise)", n, 2);
    waitToggle(n);
    check(n == 2 && sclkFall, "R7 new ratio high half", n, 2);
    rangeSel = 1'b0;                      // switch range just after a fall
    expVal   = 4'd4;
    waitToggle(n);
    check(n == 2, "R7 low half keeps old range", n, 2);
    waitToggle(n);
    check(n == 2, "R7 high half keeps old range", n, 2);
    waitToggle(n);
    check(n == 8, "R7 R1 power range after boundary", n, 8);
    waitToggle(n);
    check(n == 8, "R7 power range high half", n, 8);
    enable = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testLinear();
    testPower();
    testIdle();
    testChange();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFail);
      $finish;
    end
  end
endmodule